// File: doc/BRIEF.md
# Serial command to AXI4-Lite bridge

This block lets a host on a serial link reach a register-mapped peripheral. Bytes from a UART receiver arrive on a valid/ready byte input and are gathered into fixed seven-byte commands. Each command holds an opcode, a 16-bit register address and a 32-bit data word. Once a command is complete, the block runs exactly one AXI4-Lite master transaction. A write stores the data word. A read fetches a word, which the block sends back to the host on a valid/ready byte output.

Every command ends with a status byte returned to the host. While a command is in progress the input stalls, so the host can stream commands back to back without any flow control of its own.

Top module: `cmd_axil_bridge`

## Requirements
- R1: A command opens with an opcode byte: 0x77 requests a write and 0x72 requests a read. Any other byte in the opcode position is dropped, and the block keeps waiting for an opcode.
- R2: After the opcode, the block takes two address bytes and then four data bytes, each field sent most-significant byte first. A command is always seven bytes long, read commands included.
- R3: No AXI valid or ready output is asserted before the seventh byte of a command has been accepted. After reset all of them are low.
- R4: For a write, AWVALID and WVALID are raised in the same cycle, and each is held with stable payload until its own handshake. AWADDR is the 16-bit address zero-extended, WDATA is the data word, WSTRB is all ones and AWPROT is zero.
- R5: For a write, BREADY stays high until BVALID is seen. One status byte then goes to the host: 0x00 for OKAY, or the 2-bit BRESP value zero-extended.
- R6: For a read, ARVALID is held with stable ARADDR until ARREADY. ARADDR is the address zero-extended and ARPROT is zero. RREADY is then held until RVALID.
- R7: For a read, four bytes of RDATA go to the host most-significant byte first, followed by a status byte holding RRESP zero-extended.
- R8: The data bytes of a read command have no effect on the peripheral.
- R9: The input ready is low from the cycle after the seventh byte is accepted until the last response byte is taken, and high in the cycle after that.
- R10: While the output valid is high and the output ready is low, the output valid stays high and the output byte does not change.
- R11: Each command causes exactly one address handshake: one AW and one W handshake for a write, one AR handshake for a read, and never both kinds at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Incoming command byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Block can accept a byte |
| tx_data | output | 8 | Outgoing response byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Host side takes the byte |
| m_awaddr | output | AXI_ADDR_W | Write address |
| m_awprot | output | 3 | Write protection, zero |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write strobes, all ones |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | AXI_ADDR_W | Read address |
| m_arprot | output | 3 | Read protection, zero |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response code |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
The assertions check the bus discipline on every cycle:
- AW and W rise together.
- Each valid is held with a stable address until its handshake.
- BREADY is held until the response arrives.
- Output bytes stay stable under backpressure.
- Write and read traffic never overlap.
- The input stays stalled whenever a transaction or response is in flight.

Only the bench scenarios can show the byte-level meaning of a command. That covers the ordering of address and data bytes, the dropping of stray opcodes and the absence of bus activity after six bytes. It also covers the values returned after error responses and the fact that the data bytes of a read never reach the peripheral.

// File: rtl/cab_pkg.sv
package cab_pkg;
  localparam logic [7:0] OPC_READ  = 8'h72;
  localparam logic [7:0] OPC_WRITE = 8'h77;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_WRITE,
    ENG_RADDR,
    ENG_RDATA
  } eng_state_e;
endpackage

// File: rtl/cab_cmd_collector.sv
module cab_cmd_collector #(
  parameter int CMD_ADDR_W = 16,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [7:0]            rx_data,
  input  logic                  rx_valid,
  output logic                  rx_ready,
  input  logic                  release_cmd,
  output logic                  cmd_valid,
  output logic                  cmd_write,
  output logic [CMD_ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0]     cmd_data
);
  import cab_pkg::*;

  localparam int ADDR_BYTES = CMD_ADDR_W / 8;
  localparam int DATA_BYTES = DATA_W / 8;
  localparam int CMD_BYTES  = 1 + ADDR_BYTES + DATA_BYTES;
  localparam int CNT_W      = $clog2(CMD_BYTES);
  localparam int PAY_W      = CMD_ADDR_W + DATA_W;

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [PAY_W-1:0] payload;
  logic             take;

  assign rx_ready = !busy;
  assign take     = rx_valid && !busy;
  assign cmd_addr = payload[PAY_W-1 -: CMD_ADDR_W];
  assign cmd_data = payload[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      payload   <= '0;
      cmd_valid <= 1'b0;
      cmd_write <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      if (take) begin
        if (cnt == '0) begin
          // opcode slot: unknown bytes leave the counter at zero
          if (rx_data == OPC_WRITE || rx_data == OPC_READ) begin
            cmd_write <= (rx_data == OPC_WRITE);
            cnt       <= CNT_W'(1);
          end
        end else begin
          payload <= {payload[PAY_W-9:0], rx_data};
          if (cnt == CNT_W'(CMD_BYTES - 1)) begin
            cnt       <= '0;
            busy      <= 1'b1;
            cmd_valid <= 1'b1;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      end
      if (release_cmd) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/cab_axil_engine.sv
module cab_axil_engine #(
  parameter int AXI_ADDR_W = 32,
  parameter int CMD_ADDR_W = 16,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid,
  input  logic                  cmd_write,
  input  logic [CMD_ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0]     cmd_data,
  output logic [AXI_ADDR_W-1:0] m_awaddr,
  output logic                  m_awvalid,
  input  logic                  m_awready,
  output logic [DATA_W-1:0]     m_wdata,
  output logic                  m_wvalid,
  input  logic                  m_wready,
  input  logic [1:0]            m_bresp,
  input  logic                  m_bvalid,
  output logic                  m_bready,
  output logic [AXI_ADDR_W-1:0] m_araddr,
  output logic                  m_arvalid,
  input  logic                  m_arready,
  input  logic [DATA_W-1:0]     m_rdata,
  input  logic [1:0]            m_rresp,
  input  logic                  m_rvalid,
  output logic                  m_rready,
  output logic                  rsp_valid,
  output logic                  rsp_write,
  output logic [DATA_W-1:0]     rsp_data,
  output logic [7:0]            rsp_status
);
  import cab_pkg::*;

  eng_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ENG_IDLE;
      m_awaddr   <= '0;
      m_awvalid  <= 1'b0;
      m_wdata    <= '0;
      m_wvalid   <= 1'b0;
      m_bready   <= 1'b0;
      m_araddr   <= '0;
      m_arvalid  <= 1'b0;
      m_rready   <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_write  <= 1'b0;
      rsp_data   <= '0;
      rsp_status <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ENG_IDLE: begin
          if (cmd_valid) begin
            if (cmd_write) begin
              m_awaddr  <= AXI_ADDR_W'(cmd_addr);
              m_wdata   <= cmd_data;
              m_awvalid <= 1'b1;
              m_wvalid  <= 1'b1;
              m_bready  <= 1'b1;
              state     <= ENG_WRITE;
            end else begin
              m_araddr  <= AXI_ADDR_W'(cmd_addr);
              m_arvalid <= 1'b1;
              state     <= ENG_RADDR;
            end
          end
        end
        ENG_WRITE: begin
          if (m_awvalid && m_awready) m_awvalid <= 1'b0;
          if (m_wvalid && m_wready)   m_wvalid  <= 1'b0;
          if (m_bvalid && m_bready) begin
            m_bready   <= 1'b0;
            rsp_valid  <= 1'b1;
            rsp_write  <= 1'b1;
            rsp_data   <= '0;
            rsp_status <= {6'b0, m_bresp};
            state      <= ENG_IDLE;
          end
        end
        ENG_RADDR: begin
          if (m_arready) begin
            m_arvalid <= 1'b0;
            m_rready  <= 1'b1;
            state     <= ENG_RDATA;
          end
        end
        ENG_RDATA: begin
          if (m_rvalid) begin
            m_rready   <= 1'b0;
            rsp_valid  <= 1'b1;
            rsp_write  <= 1'b0;
            rsp_data   <= m_rdata;
            rsp_status <= {6'b0, m_rresp};
            state      <= ENG_IDLE;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cab_rsp_serializer.sv
module cab_rsp_serializer #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rsp_valid,
  input  logic              rsp_write,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [7:0]        rsp_status,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              last_sent
);
  localparam int DATA_BYTES = DATA_W / 8;
  localparam int SH_W       = DATA_W + 8;
  localparam int LEFT_W     = $clog2(DATA_BYTES + 2);

  logic [SH_W-1:0]   shreg;
  logic [LEFT_W-1:0] left;

  assign tx_data   = shreg[SH_W-1 -: 8];
  assign last_sent = tx_valid && tx_ready && (left == LEFT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      left     <= '0;
      tx_valid <= 1'b0;
    end else if (rsp_valid) begin
      tx_valid <= 1'b1;
      if (rsp_write) begin
        shreg <= {rsp_status, {DATA_W{1'b0}}};
        left  <= LEFT_W'(1);
      end else begin
        shreg <= {rsp_data, rsp_status};
        left  <= LEFT_W'(DATA_BYTES + 1);
      end
    end else if (tx_valid && tx_ready) begin
      shreg <= {shreg[SH_W-9:0], 8'h00};
      left  <= left - LEFT_W'(1);
      if (left == LEFT_W'(1)) tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_axil_bridge.sv
module cmd_axil_bridge #(
  parameter int AXI_ADDR_W = 32,
  parameter int CMD_ADDR_W = 16,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [7:0]            rx_data,
  input  logic                  rx_valid,
  output logic                  rx_ready,
  output logic [7:0]            tx_data,
  output logic                  tx_valid,
  input  logic                  tx_ready,
  output logic [AXI_ADDR_W-1:0] m_awaddr,
  output logic [2:0]            m_awprot,
  output logic                  m_awvalid,
  input  logic                  m_awready,
  output logic [DATA_W-1:0]     m_wdata,
  output logic [DATA_W/8-1:0]   m_wstrb,
  output logic                  m_wvalid,
  input  logic                  m_wready,
  input  logic [1:0]            m_bresp,
  input  logic                  m_bvalid,
  output logic                  m_bready,
  output logic [AXI_ADDR_W-1:0] m_araddr,
  output logic [2:0]            m_arprot,
  output logic                  m_arvalid,
  input  logic                  m_arready,
  input  logic [DATA_W-1:0]     m_rdata,
  input  logic [1:0]            m_rresp,
  input  logic                  m_rvalid,
  output logic                  m_rready
);
  logic                  cmd_valid;
  logic                  cmd_write;
  logic [CMD_ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0]     cmd_data;
  logic                  rsp_valid;
  logic                  rsp_write;
  logic [DATA_W-1:0]     rsp_data;
  logic [7:0]            rsp_status;
  logic                  last_sent;

  assign m_awprot = 3'b000;
  assign m_arprot = 3'b000;
  assign m_wstrb  = '1;

  cab_cmd_collector #(.CMD_ADDR_W(CMD_ADDR_W), .DATA_W(DATA_W)) u_collect (
    .clk(clk), .rst(rst),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .release_cmd(last_sent),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  cab_axil_engine #(.AXI_ADDR_W(AXI_ADDR_W), .CMD_ADDR_W(CMD_ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .m_araddr(m_araddr), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write),
    .rsp_data(rsp_data), .rsp_status(rsp_status)
  );

  cab_rsp_serializer #(.DATA_W(DATA_W)) u_serial (
    .clk(clk), .rst(rst),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write),
    .rsp_data(rsp_data), .rsp_status(rsp_status),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .last_sent(last_sent)
  );
endmodule

// File: rtl/cab_bridge_checker.sv
module cab_bridge_checker #(
  parameter int AXI_ADDR_W = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  rx_ready,
  input logic [7:0]            tx_data,
  input logic                  tx_valid,
  input logic                  tx_ready,
  input logic [AXI_ADDR_W-1:0] m_awaddr,
  input logic                  m_awvalid,
  input logic                  m_awready,
  input logic                  m_wvalid,
  input logic                  m_wready,
  input logic                  m_bvalid,
  input logic                  m_bready,
  input logic [AXI_ADDR_W-1:0] m_araddr,
  input logic                  m_arvalid,
  input logic                  m_arready,
  input logic                  m_rvalid,
  input logic                  m_rready
);
  // R4: address and data channels open together
  a_r4_aw_w_together: assert property (@(posedge clk) disable iff (rst)
    $rose(m_awvalid) |-> $rose(m_wvalid));

  // R4: write address held until accepted
  a_r4_aw_hold: assert property (@(posedge clk) disable iff (rst)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));

  // R4: write data held until accepted
  a_r4_w_hold: assert property (@(posedge clk) disable iff (rst)
    m_wvalid && !m_wready |=> m_wvalid);

  // R5: response ready held until the response shows up
  a_r5_bready_hold: assert property (@(posedge clk) disable iff (rst)
    m_bready && !m_bvalid |=> m_bready);

  // R6: read address held until accepted, read data ready held
  a_r6_ar_hold: assert property (@(posedge clk) disable iff (rst)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr));

  a_r6_rready_hold: assert property (@(posedge clk) disable iff (rst)
    m_rready && !m_rvalid |=> m_rready);

  // R10: output byte stable under backpressure
  a_r10_tx_stable: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R9: input stalled while the bus or the response path is busy
  a_r9_stall_busy: assert property (@(posedge clk) disable iff (rst)
    (m_awvalid || m_wvalid || m_bready || m_arvalid || m_rready || tx_valid) |-> !rx_ready);

  // R11: write and read traffic never overlap
  a_r11_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !((m_awvalid || m_wvalid || m_bready) && (m_arvalid || m_rready)));
endmodule

bind cmd_axil_bridge cab_bridge_checker #(.AXI_ADDR_W(AXI_ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rx_ready(rx_ready),
  .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
  .m_wvalid(m_wvalid), .m_wready(m_wready),
  .m_bvalid(m_bvalid), .m_bready(m_bready),
  .m_araddr(m_araddr), .m_arvalid(m_arvalid), .m_arready(m_arready),
  .m_rvalid(m_rvalid), .m_rready(m_rready)
);

// File: tb/cmd_axil_bridge_tb.sv
`timescale 1ns/1ps
module cmd_axil_bridge_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [7:0]  rx_data = 8'h00;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [31:0] m_awaddr, m_araddr, m_wdata, m_rdata;
  logic [2:0]  m_awprot, m_arprot;
  logic [3:0]  m_wstrb;
  logic        m_awvalid, m_awready, m_wvalid, m_wready, m_bvalid, m_bready;
  logic        m_arvalid, m_arready, m_rvalid, m_rready;
  logic [1:0]  m_bresp, m_rresp;

  cmd_axil_bridge u_dut (
    .clk(clk), .rst(rst),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .m_awaddr(m_awaddr), .m_awprot(m_awprot), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .m_araddr(m_araddr), .m_arprot(m_arprot), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- register-file slave model ----------------
  logic [31:0] mem [16];
  logic        aw_hold, w_hold, ar_hold;
  logic [31:0] aw_l, wd_l, ar_l;
  logic [2:0]  awprot_l, arprot_l;
  logic [3:0]  ws_l;
  logic [1:0]  wdly;
  int          aw_cnt, w_cnt, ar_cnt;

  always @(posedge clk) begin
    if (rst) begin
      m_awready <= 0; m_wready <= 0; m_arready <= 0;
      m_bvalid <= 0; m_rvalid <= 0; m_bresp <= 0; m_rresp <= 0; m_rdata <= 0;
      aw_hold <= 0; w_hold <= 0; ar_hold <= 0; wdly <= 0;
      aw_l <= 0; wd_l <= 0; ar_l <= 0; ws_l <= 0; awprot_l <= 0; arprot_l <= 0;
      aw_cnt <= 0; w_cnt <= 0; ar_cnt <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= 32'h0;
    end else begin
      m_awready <= 0; m_wready <= 0; m_arready <= 0;
      if (m_awvalid && !m_awready && !aw_hold) begin
        m_awready <= 1; aw_hold <= 1; aw_l <= m_awaddr; awprot_l <= m_awprot; aw_cnt <= aw_cnt + 1;
      end
      if (m_wvalid && !m_wready && !w_hold) begin
        if (wdly == 2'd2) begin
          m_wready <= 1; w_hold <= 1; wd_l <= m_wdata; ws_l <= m_wstrb; w_cnt <= w_cnt + 1; wdly <= 0;
        end else wdly <= wdly + 1;
      end
      if (aw_hold && w_hold && !m_bvalid) begin
        m_bvalid <= 1;
        if (aw_l[15:12] != 0) m_bresp <= 2'd2;
        else begin m_bresp <= 2'd0; mem[aw_l[5:2]] <= wd_l; end
      end
      if (m_bvalid && m_bready) begin m_bvalid <= 0; aw_hold <= 0; w_hold <= 0; end
      if (m_arvalid && !m_arready && !ar_hold) begin
        m_arready <= 1; ar_hold <= 1; ar_l <= m_araddr; arprot_l <= m_arprot; ar_cnt <= ar_cnt + 1;
      end
      if (ar_hold && !m_rvalid && !m_arready) begin
        m_rvalid <= 1;
        if (ar_l[15:12] != 0) begin m_rresp <= 2'd2; m_rdata <= 32'h0; end
        else begin m_rresp <= 2'd0; m_rdata <= mem[ar_l[5:2]]; end
      end
      if (m_rvalid && m_rready) begin m_rvalid <= 0; ar_hold <= 0; end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { logic [7:0] b; string tag; } exp_t;
  exp_t sb_q[$];
  logic [31:0] shadow [16];
  int stall = 0;
  logic prev_hold = 0;
  logic [7:0] prev_byte = 0;
  logic prev_aw = 0;

  always @(negedge clk) begin
    stall++;
    if (!rst) begin
      if (prev_hold) chk(tx_valid && tx_data == prev_byte, "R10 held byte", {55'd0, tx_valid, tx_data}, {56'd1, prev_byte});
      if (!prev_aw && m_awvalid) chk(m_wvalid, "R4 aw/w together", m_wvalid, 1);
    end
    prev_aw = m_awvalid;
    tx_ready = (stall % 3) != 0;
    prev_hold = !rst && tx_valid && !tx_ready;
    prev_byte = tx_data;
    if (!rst && tx_valid && tx_ready) begin
      if (sb_q.size() == 0) chk(0, "R7 unexpected byte", tx_data, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(tx_data == e.b, e.tag, tx_data, e.b);
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic run_cmd(input logic [7:0] opc, input logic [15:0] a, input logic [31:0] d, input bit pause6);
    int aw0, w0, ar0;
    bit err;
    logic [31:0] rv;
    err = (a[15:12] != 0);
    aw0 = aw_cnt; w0 = w_cnt; ar0 = ar_cnt;
    if (opc == 8'h77) begin
      sb_q.push_back('{err ? 8'h02 : 8'h00, "R5 write status"});
      if (!err) shadow[a[5:2]] = d;
    end else begin
      rv = err ? 32'h0 : shadow[a[5:2]];
      for (int k = 3; k >= 0; k--) sb_q.push_back('{rv[k*8 +: 8], "R7 read byte"});
      sb_q.push_back('{err ? 8'h02 : 8'h00, "R7 read status"});
    end
    send_byte(opc); send_byte(a[15:8]); send_byte(a[7:0]);
    send_byte(d[31:24]); send_byte(d[23:16]); send_byte(d[15:8]);
    if (pause6) begin
      @(negedge clk); rx_valid = 0;
      repeat (6) @(negedge clk);
      chk(!m_awvalid && !m_wvalid && !m_arvalid && !m_bready && !m_rready, "R3 six bytes no bus",
          {m_awvalid, m_wvalid, m_arvalid}, 0);
    end
    send_byte(d[7:0]);
    @(negedge clk); rx_valid = 0;
    chk(rx_ready == 0, "R9 stall after seventh", rx_ready, 0);
    while (!rx_ready) @(negedge clk);
    chk(sb_q.size() == 0, "R9 ready after last byte", sb_q.size(), 0);
    if (opc == 8'h77) begin
      chk(aw_cnt - aw0 == 1 && w_cnt - w0 == 1 && ar_cnt == ar0, "R11 write count", aw_cnt - aw0, 1);
      chk(aw_l == {16'h0, a}, "R4 awaddr", aw_l, {16'h0, a});
      chk(wd_l == d && ws_l == 4'hF && awprot_l == 0, "R4 wdata/wstrb/prot", {ws_l, wd_l}, {4'hF, d});
    end else begin
      chk(ar_cnt - ar0 == 1 && aw_cnt == aw0 && w_cnt == w0, "R11 read count", ar_cnt - ar0, 1);
      chk(ar_l == {16'h0, a} && arprot_l == 0, "R6 araddr/prot", ar_l, {16'h0, a});
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = 32'h0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(rx_ready && !tx_valid, "R9 reset ready", {rx_ready, tx_valid}, 2'b10);
    chk(!m_awvalid && !m_wvalid && !m_bready && !m_arvalid && !m_rready, "R3 reset bus idle",
        {m_awvalid, m_wvalid, m_arvalid}, 0);

    // R2/R4/R5: write with distinct bytes, MSB first
    run_cmd(8'h77, 16'h0010, 32'hA5C3_1E77, 0);
    // R7/R8: read back, data bytes carry a different word
    run_cmd(8'h72, 16'h0010, 32'hDEAD_BEEF, 0);
    chk(mem[4] == 32'hA5C3_1E77, "R8 read data ignored", mem[4], 32'hA5C3_1E77);

    // R3: pause after six bytes
    run_cmd(8'h77, 16'h0020, 32'h1122_3344, 1);

    // R1: stray bytes dropped, including a byte equal to the write opcode's neighbour
    send_byte(8'h41); send_byte(8'h00); send_byte(8'h76);
    @(negedge clk); rx_valid = 0;
    repeat (4) @(negedge clk);
    chk(!m_awvalid && !m_arvalid && !tx_valid, "R1 bad opcode no action", {m_awvalid, m_arvalid}, 0);
    run_cmd(8'h72, 16'h0020, 32'h0, 0);

    // R5/R7: error responses, no update of storage
    run_cmd(8'h77, 16'h1004, 32'hFFFF_0000, 0);
    run_cmd(8'h72, 16'h1004, 32'h0, 0);
    run_cmd(8'h72, 16'h0004, 32'h0, 0);

    // several patterns across the register file
    for (int i = 0; i < 16; i++) run_cmd(8'h77, 16'(i * 4), 32'h1357_9BDF ^ (i * 32'h0102_0408), 0);
    for (int i = 15; i >= 0; i -= 3) run_cmd(8'h72, 16'(i * 4), 32'h5555_AAAA, 0);
    chk(mem[5] == (32'h1357_9BDF ^ (5 * 32'h0102_0408)), "R2 stored word", mem[5], 32'h1357_9BDF ^ (5 * 32'h0102_0408));

    repeat (10) @(negedge clk);
    chk(sb_q.size() == 0 && !tx_valid, "R7 no extra bytes", sb_q.size(), 0);
    finish_run();
  end
endmodule